// File: doc/BRIEF.md
# Two-Phase Interpolating FIR

This block is the upsampling filter on the reconstruction side of a two-channel subband system. A channel sample arrives on a strobe every second clock. The filter produces one output sample on every clock. The result matches inserting a zero after each channel sample and then convolving with an NTAPS-long impulse response. No multiply is ever spent on a stuffed zero.

Each multiplier handles one pair of neighbouring taps. On the clock right after a sample is captured, the multiplier uses its even-indexed coefficient. On the clock after that, it uses its odd-indexed coefficient on the same held sample. A pipelined adder tree sums the products of one phase at a time. The even-phase sum and the odd-phase sum therefore leave the block as two consecutive output samples and are never added to each other.

The impulse response is a parameter, so one instance covers any length, either even or odd. The output keeps full precision, so the next stage decides where to round.

Top module: `interp_fir`

## Requirements
- R1: While reset is asserted, and after it is released, out_valid is 0, out_data is 0 and the sample history is all zeros. A reset in the middle of a stream discards every earlier sample.
- R2: A channel sample is taken only on a cycle where in_valid is 1. Successive strobes are at least two cycles apart. The value on in_data during any other cycle has no effect on any output.
- R3: For the accepted samples x[0], x[1], ..., in order, the output stream is y[2n] = sum over k of h[2k]·x[n−k], followed by y[2n+1] = sum over k of h[2k+1]·x[n−k]. Here h[i] is the signed two's complement field COEFS[i·CW +: CW] and x is signed two's complement. Each accepted sample yields exactly two outputs, even phase first.
- R4: When NTAPS is odd, the missing final odd coefficient counts as zero. An impulse therefore reproduces h[0..NTAPS−1] followed by zeros.
- R5: The even-phase result of the first sample after reset appears with out_valid = 1 on the LAT-th rising edge after the edge that samples the strobe, and out_valid stays 0 before that edge. LAT = 1 + ceil(log2(ceil(NTAPS/2))).
- R6: While strobes arrive on every second cycle, out_valid stays 1 on every cycle from the first output onward.
- R7: out_data is DW+CW+ceil(log2(ceil(NTAPS/2))) bits wide and carries the exact signed sum. Full-scale inputs and coefficients do not overflow it.
- R8: A pause in the strobes keeps the sample history. After the pause, outputs continue the same convolution over the accepted samples only.
- R9: out_valid is 1 only within LAT+1 cycles after a strobe. Once the strobes stop, the pipeline drains and out_valid falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe marking a new channel sample |
| in_data | input | DW | Signed channel sample |
| out_valid | output | 1 | Output sample present this cycle |
| out_data | output | DW+CW+ceil(log2(ceil(NTAPS/2))) | Signed full-rate output sample |

## Verification
The bench runs an odd-length response. An impulse there exposes a design that gives the last odd-phase multiplier a non-zero coefficient, or that swaps the two phases: the reproduced response would come out shifted or scrambled. Full-scale samples with the most negative and most positive coefficients catch a truncated output width, which would show up as wrapped sums. Random data on the off-strobe cycles catches a tap line that shifts every clock instead of only on strobes: the history would fill with junk. A pause between bursts, and a reset in the middle of a burst, separate a design that keeps its history correctly from one that clears it, or keeps it, at the wrong moment.

// File: rtl/interp_fir_pkg.sv
package interp_fir_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    function automatic int mul_count(input int ntaps);
        return (ntaps + 1) / 2;
    endfunction

endpackage

// File: rtl/interp_fir_tapline.sv
module interp_fir_tapline
    import interp_fir_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NMUL = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [DW-1:0]                  in_data,
    output logic [NMUL-1:0][DW-1:0]        taps_o,
    output phase_e                         phase_o,
    output logic                           act_o
);

    typedef struct packed {
        logic [NMUL-1:0][DW-1:0] taps;
        phase_e                  phase;
        logic                    act;
    } tl_s;

    tl_s st_d, st_q;

    // The history shifts only on a strobe; the phase walks even then odd.
    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.taps[0] = in_data;
            for (int k = 1; k < NMUL; k++) begin
                st_d.taps[k] = st_q.taps[k-1];
            end
            st_d.phase = PH_EVEN;
            st_d.act   = 1'b1;
        end else if (st_q.act && st_q.phase == PH_EVEN) begin
            st_d.phase = PH_ODD;
        end else begin
            st_d.phase = PH_EVEN;
            st_d.act   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taps_o  = st_q.taps;
    assign phase_o = st_q.phase;
    assign act_o   = st_q.act;

endmodule

// File: rtl/interp_fir_mulbank.sv
module interp_fir_mulbank
    import interp_fir_pkg::*;
#(
    parameter int                     DW    = 16,
    parameter int                     CW    = 16,
    parameter int                     NTAPS = 8,
    parameter logic [NTAPS*CW-1:0]    COEFS = '0,
    parameter int                     NMUL  = 4,
    parameter int                     PW    = DW + CW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NMUL-1:0][DW-1:0]    taps_i,
    input  phase_e                     phase_i,
    input  logic                       act_i,
    output logic [NMUL-1:0][PW-1:0]    prod_o,
    output logic                       vld_o
);

    typedef struct packed {
        logic [NMUL-1:0][PW-1:0] p;
        logic                    vld;
    } mb_s;

    mb_s st_d, st_q;

    logic [CW-1:0] cev [NMUL];
    logic [CW-1:0] cod [NMUL];

    // Each multiplier owns one neighbouring pair of taps.
    for (genvar k = 0; k < NMUL; k++) begin : g_pair
        localparam int IE = 2 * k;
        localparam int IO = 2 * k + 1;
        assign cev[k] = COEFS[IE*CW +: CW];
        if (IO < NTAPS) begin : g_odd
            assign cod[k] = COEFS[IO*CW +: CW];
        end else begin : g_pad
            assign cod[k] = '0;
        end
    end

    always_comb begin
        logic signed [PW-1:0] a_ext;
        logic signed [PW-1:0] c_ext;
        st_d     = st_q;
        st_d.vld = act_i;
        for (int k = 0; k < NMUL; k++) begin
            a_ext = PW'($signed(taps_i[k]));
            c_ext = (phase_i == PH_ODD) ? PW'($signed(cod[k])) : PW'($signed(cev[k]));
            st_d.p[k] = a_ext * c_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_o = st_q.p;
    assign vld_o  = st_q.vld;

endmodule

// File: rtl/interp_fir_addtree.sv
module interp_fir_addtree #(
    parameter int WI  = 32,
    parameter int N   = 4,
    parameter int LVL = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0][WI-1:0]     in_i,
    input  logic                     vld_i,
    output logic [WI+LVL-1:0]        sum_o,
    output logic                     vld_o
);

    localparam int WO    = WI + LVL;
    localparam int NLEAF = 1 << LVL;

    if (LVL == 0) begin : g_pass
        assign sum_o = in_i[0];
        assign vld_o = vld_i;
    end else begin : g_tree
        logic [WO-1:0] leaf   [NLEAF];
        logic [WO-1:0] node_d [1:NLEAF-1];
        logic [WO-1:0] node_q [1:NLEAF-1];
        logic [LVL-1:0] vs_d, vs_q;

        for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
            if (i < N) begin : g_used
                assign leaf[i] = WO'($signed(in_i[i]));
            end else begin : g_zero
                assign leaf[i] = '0;
            end
        end

        // Heap order: node i adds children 2i and 2i+1, leaves follow the last node.
        for (genvar i = 1; i < NLEAF; i++) begin : g_node
            localparam int C = 2 * i;
            if (C >= NLEAF) begin : g_bottom
                assign node_d[i] = leaf[C-NLEAF] + leaf[C+1-NLEAF];
            end else begin : g_inner
                assign node_d[i] = node_q[C] + node_q[C+1];
            end
        end

        assign vs_d = (vs_q << 1) | LVL'(vld_i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 1; i < NLEAF; i++) node_q[i] <= '0;
                vs_q <= '0;
            end else begin
                for (int i = 1; i < NLEAF; i++) node_q[i] <= node_d[i];
                vs_q <= vs_d;
            end
        end

        assign sum_o = node_q[1];
        assign vld_o = vs_q[LVL-1];
    end

endmodule

// File: rtl/interp_fir.sv
module interp_fir
    import interp_fir_pkg::*;
#(
    parameter int                  DW    = 16,
    parameter int                  CW    = 16,
    parameter int                  NTAPS = 8,
    parameter logic [NTAPS*CW-1:0] COEFS = {16'd9, 16'hFFF9, 16'd21, 16'd40,
                                            16'd40, 16'd21, 16'hFFF9, 16'd9},
    localparam int NMUL = mul_count(NTAPS),
    localparam int LVL  = $clog2(NMUL),
    localparam int PW   = DW + CW,
    localparam int OW   = PW + LVL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);

    logic [NMUL-1:0][DW-1:0] taps;
    phase_e                  phase;
    logic                    act;
    logic [NMUL-1:0][PW-1:0] prods;
    logic                    prod_vld;

    interp_fir_tapline #(
        .DW   (DW),
        .NMUL (NMUL)
    ) u_tapline (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .taps_o   (taps),
        .phase_o  (phase),
        .act_o    (act)
    );

    interp_fir_mulbank #(
        .DW    (DW),
        .CW    (CW),
        .NTAPS (NTAPS),
        .COEFS (COEFS),
        .NMUL  (NMUL),
        .PW    (PW)
    ) u_mulbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .taps_i  (taps),
        .phase_i (phase),
        .act_i   (act),
        .prod_o  (prods),
        .vld_o   (prod_vld)
    );

    interp_fir_addtree #(
        .WI  (PW),
        .N   (NMUL),
        .LVL (LVL)
    ) u_addtree (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (prods),
        .vld_i (prod_vld),
        .sum_o (out_data),
        .vld_o (out_valid)
    );

endmodule

// File: rtl/interp_fir_chk.sv
module interp_fir_chk #(
    parameter int NTAPS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid
);

    localparam int LAT = 1 + $clog2((NTAPS + 1) / 2);

    logic started_q;
    int   fcnt_q;
    int   idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            fcnt_q    <= 0;
            idle_q    <= LAT + 2;
        end else begin
            if (in_valid && !started_q) begin
                started_q <= 1'b1;
                fcnt_q    <= 0;
            end else if (started_q && fcnt_q <= LAT) begin
                fcnt_q <= fcnt_q + 1;
            end
            if (in_valid) idle_q <= 0;
            else if (idle_q < LAT + 2) idle_q <= idle_q + 1;
        end
    end

    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!started_q || fcnt_q < LAT) |-> !out_valid); // R5
    AST_FIRST_OUT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && fcnt_q == LAT) |-> out_valid); // R5
    AST_OUT_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |=> out_valid); // R3
    AST_OUT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (idle_q <= LAT + 1)); // R9

endmodule

bind interp_fir interp_fir_chk #(.NTAPS(NTAPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid)
);

// File: tb/interp_fir_bench.sv
module interp_fir_bench;

    localparam int DW    = 16;
    localparam int CW    = 16;
    localparam int NTAPS = 7;
    localparam int NMUL  = (NTAPS + 1) / 2;
    localparam int LVL   = $clog2(NMUL);
    localparam int LAT   = 1 + LVL;
    localparam int OW    = DW + CW + LVL;
    localparam logic [NTAPS*CW-1:0] BCOEF = {16'h8000, 16'd17, 16'hFFF3, 16'd11,
                                             16'd7, 16'hFFFB, 16'h7FFF};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;

    always #5 clk = ~clk;

    interp_fir #(
        .DW    (DW),
        .CW    (CW),
        .NTAPS (NTAPS),
        .COEFS (BCOEF)
    ) u_interp_fir (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    longint xs [4096];
    int     nx = 0;
    int     jo = 0;
    string  tag = "R1";
    bit     done = 1'b0;

    function automatic longint hc(input int i);
        if (i >= NTAPS) return 0;
        return longint'($signed(BCOEF[i*CW +: CW]));
    endfunction

    // Zero-stuffed convolution, evaluated per output index.
    function automatic longint expv(input int j);
        longint s = 0;
        int n = j / 2;
        int ph = j % 2;
        for (int k = 0; k < NMUL; k++) begin
            if (n - k >= 0) s += hc(2 * k + ph) * xs[n-k];
        end
        return s;
    endfunction

    function automatic logic [DW-1:0] gen(input int kind, input int i);
        case (kind)
            1:       return (i == 0) ? 16'd1 : 16'd0;
            2:       return (i % 2 != 0) ? 16'h7FFF : 16'h8000;
            3:       return 16'h8000;
            default: return DW'($urandom);
        endcase
    endfunction

    task automatic chk(input string rq, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (jo >= 2 * nx) begin
                chk({tag, " R3 extra output"}, 1, 0);
            end else begin
                chk(tag, longint'($signed(out_data)), expv(jo));
                jo++;
            end
        end
    end

    task automatic burst(input int n, input int kind, input bit lat_chk);
        logic [DW-1:0] x;
        for (int k = 0; k < 2 * n; k++) begin
            @(negedge clk);
            if (lat_chk && k >= 1 && k <= LAT) chk("R5 early output", longint'(out_valid), 0);
            if (lat_chk && k == LAT + 1) chk("R5 first output", longint'(out_valid), 1);
            if (k >= LAT + 1) chk("R6 continuous valid", longint'(out_valid), 1);
            if (k % 2 == 0) begin
                x = gen(kind, k / 2);
                in_valid = 1'b1;
                in_data  = x;
                xs[nx]   = longint'($signed(x));
                nx++;
            end else begin
                in_valid = 1'b0;
                in_data  = DW'($urandom);   // R2: junk between strobes
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (LAT + 3) @(negedge clk);
        chk("R9 idle after drain", longint'(out_valid), 0);
        chk("R3 two outputs per sample", jo, 2 * nx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset valid", longint'(out_valid), 0);
        chk("R1 reset data", longint'(out_data), 0);
        nx = 0;
        jo = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tag = "R1";
        do_reset();
        tag = "R4 impulse";
        burst(6, 1, 1);
        drain();
        tag = "R3 random";
        burst(40, 0, 0);
        drain();
        tag = "R8 after pause";
        burst(30, 0, 0);
        drain();
        tag = "R7 full scale";
        burst(20, 2, 0);
        burst(12, 3, 0);
        drain();
        tag = "R2 junk between strobes";
        burst(25, 0, 0);
        drain();
        tag = "R1 mid-stream";
        burst(5, 0, 0);
        do_reset();
        tag = "R1 history cleared";
        burst(8, 0, 1);
        drain();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule